// File: doc/BRIEF.md
# Serial channel I/O pin configuration

This block sets up the four general I/O pins that belong to one serial channel, using a single 8-bit configuration register. The register has four 2-bit fields, one for each pin. A field either leaves its pin as an input or drives the pin from one internal signal. The possible sources are:

- a bit of the port output latch;
- the transmit clock at 1x or 16x;
- the receive clock at 1x or 16x;
- the request-to-send line, active low;
- an end-of-transmission flag.

The request-to-send line normally appears on pin 2. When pin 2 is given some other job, the line moves to pin 1 instead. This lets a smaller pin set still carry clear-to-send, request-to-send and an external receive clock at the same time.

Each pin input passes through a synchronizer and then a change detector. The detector watches the pin whenever the pin is not driven by the block, and this includes the time the pin serves as a clock or clear-to-send input. A detected change sets a sticky flag. Logic outside the block can poll the flags and clears them with a write-one-to-clear strobe. The flags, masked by a per-pin enable, combine into one registered interrupt.

The baud generator, the flow control logic and the pad drivers are outside the block. They connect to it through plain inputs and outputs.

Top module: `uart_iopin_cfg`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all of the following hold: the configuration register is 0x00, `pin_oe` is 0, `pin_out` is 0, `chg_flags` is 0 and `irq` is 0.
- R2: For every pin, field code 00 makes the pin an input (`pin_oe` bit 0, `pin_out` bit 0). Pin 1's reserved code 10 also makes that pin an input. No error indication exists.
- R3: Pin 3 is controlled by bits 7:6. Code 01 drives `out_latch[3]`, code 10 drives `txc16x` and code 11 drives `txc1x`.
- R4: Pin 0 is controlled by bits 1:0. Code 01 drives `out_latch[0]`, code 10 drives `txc1x` and code 11 drives `txc16x`.
- R5: Pin 2 is controlled by bits 5:4. Code 10 drives `rxc1x` and code 11 drives `rxc16x`. Code 01 chooses its source in this priority order: `rts_n` if `rts_mode` is 1; otherwise `eot_flag` if `eot_mode` is 1; otherwise `out_latch[2]`.
- R6: Pin 1 is controlled by bits 3:2. Code 11 drives `rxc1x`. Code 01 drives `rts_n` when bits 5:4 are not 01 and `rts_mode` is 1; in every other case it drives `out_latch[1]`.
- R7: A configuration write (`cfg_we` high) is stored at that clock edge. `pin_oe` and `pin_out` are registered, so the pins show the stored configuration after the following edge.
- R8: `in_sync[i]` equals `pin_in[i]` delayed by SYNC_STAGES clock edges. The default is 2.
- R9: `chg_flags[i]` is set one edge after `in_sync[i]` changes, but only while pin i is an input. A flag never sets while the block drives pin i.
- R10: Change flags are sticky. A 1 on `chg_clr[i]` clears only flag i.
- R11: `irq` becomes the OR of `chg_flags & chg_en` one edge later. A flag whose enable bit is 0 does not raise `irq`.
- R12: While the synchronizer fills after reset, its contents raise no change flag. This holds even if the pins are high at reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration value: four 2-bit pin fields |
| out_latch | input | 4 | Port output latch bits |
| txc1x | input | 1 | Transmit clock, 1x |
| txc16x | input | 1 | Transmit clock, 16x |
| rxc1x | input | 1 | Receive clock, 1x |
| rxc16x | input | 1 | Receive clock, 16x |
| rts_n | input | 1 | Request-to-send from flow control, active low |
| eot_flag | input | 1 | End-of-transmission flag |
| rts_mode | input | 1 | Request-to-send pin function enable |
| eot_mode | input | 1 | End-of-transmission pin function enable |
| pin_in | input | 4 | Pad input values |
| chg_clr | input | 4 | Write-one-to-clear strobes for the change flags |
| chg_en | input | 4 | Per-pin interrupt enables |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables (1 = driven) |
| in_sync | output | 4 | Synchronized pin input values |
| chg_flags | output | 4 | Sticky change flags |
| irq | output | 1 | Change interrupt |

## Verification
The source multiplexer is tested with random configuration bytes and random source values. This separates pins that share a code but have different maps, for example code 10 on pin 0 compared with code 10 on pin 3. Directed cases cover the request-to-send fallback and its reverse, the priority of request-to-send over the end-of-transmission flag, and pin 1's reserved code.

The input side has its own directed patterns:
- A single pin toggling, which shows the synchronizer delay and the timing of the flag and the interrupt.
- Pins held high through reset release, which separates real changes from the synchronizer filling.
- A driven pin toggling, which shows that detection is off while the pin is an output.
- A masked flag, which shows that the interrupt enable works.

// File: rtl/uart_iopin_pkg.sv
package uart_iopin_pkg;

  localparam int NPINS   = 4;
  localparam int FIELD_W = 2;
  localparam int CFG_W   = NPINS * FIELD_W;

  typedef enum logic [FIELD_W-1:0] {
    FLD_INPUT = 2'b00,
    FLD_SEL_A = 2'b01,
    FLD_SEL_B = 2'b10,
    FLD_SEL_C = 2'b11
  } fld_e;

  typedef struct packed {
    logic [NPINS-1:0] latch;
    logic             txc1x;
    logic             txc16x;
    logic             rxc1x;
    logic             rxc16x;
    logic             rts_n;
    logic             eot;
    logic             rts_mode;
    logic             eot_mode;
  } src_t;

  typedef struct packed {
    logic oe;
    logic val;
  } drv_t;

  // Per-pin source decode. rts_here tells pin 1 that pin 2 has given up the RTS line.
  function automatic drv_t pin_drive(input int idx, input logic [FIELD_W-1:0] code,
                                     input logic rts_here, input src_t s);
    drv_t d;
    d = '{oe: 1'b0, val: 1'b0};
    case (idx)
      0: case (fld_e'(code))
           FLD_SEL_A: d = '{oe: 1'b1, val: s.latch[0]};
           FLD_SEL_B: d = '{oe: 1'b1, val: s.txc1x};
           FLD_SEL_C: d = '{oe: 1'b1, val: s.txc16x};
           default:   d = '{oe: 1'b0, val: 1'b0};
         endcase
      1: case (fld_e'(code))
           FLD_SEL_A: d = '{oe: 1'b1, val: (rts_here && s.rts_mode) ? s.rts_n : s.latch[1]};
           FLD_SEL_C: d = '{oe: 1'b1, val: s.rxc1x};
           default:   d = '{oe: 1'b0, val: 1'b0};
         endcase
      2: case (fld_e'(code))
           FLD_SEL_A: d = '{oe: 1'b1,
                            val: s.rts_mode ? s.rts_n : (s.eot_mode ? s.eot : s.latch[2])};
           FLD_SEL_B: d = '{oe: 1'b1, val: s.rxc1x};
           FLD_SEL_C: d = '{oe: 1'b1, val: s.rxc16x};
           default:   d = '{oe: 1'b0, val: 1'b0};
         endcase
      default: case (fld_e'(code))
           FLD_SEL_A: d = '{oe: 1'b1, val: s.latch[3]};
           FLD_SEL_B: d = '{oe: 1'b1, val: s.txc16x};
           FLD_SEL_C: d = '{oe: 1'b1, val: s.txc1x};
           default:   d = '{oe: 1'b0, val: 1'b0};
         endcase
    endcase
    return d;
  endfunction

endpackage

// File: rtl/iopin_cfg_reg.sv
module iopin_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/iopin_drive_mux.sv
module iopin_drive_mux
  import uart_iopin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  src_t             src,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  // RTS can use pin 2 only when pin 2's field selects it; otherwise pin 1 takes it.
  logic p2_takes_rts;
  assign p2_takes_rts = (cfg[5:4] == FLD_SEL_A);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    drv_t d;
    logic rts_here;
    if (g == 1) begin : g_fb
      assign rts_here = !p2_takes_rts;
    end else begin : g_nofb
      assign rts_here = 1'b1;
    end
    always_comb d = pin_drive(g, cfg[g*FIELD_W +: FIELD_W], rts_here, src);
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[g]  <= 1'b0;
        pin_out[g] <= 1'b0;
      end else begin
        pin_oe[g]  <= d.oe;
        pin_out[g] <= d.val;
      end
    end
  end
endmodule

// File: rtl/iopin_chg_det.sv
module iopin_chg_det #(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] is_input,
  input  logic [NPINS-1:0] clr,
  input  logic [NPINS-1:0] en,
  output logic [NPINS-1:0] in_sync,
  output logic [NPINS-1:0] flags,
  output logic             irq
);
  localparam int ARM_CNT = SYNC_STAGES + 1;
  localparam int PW      = $clog2(ARM_CNT + 1);

  logic [PW-1:0]    prime_cnt;
  logic             armed;
  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] changed;

  // Detection stays off until the synchronizer and history have filled after reset.
  always_ff @(posedge clk) begin
    if (rst)             prime_cnt <= '0;
    else if (!armed)     prime_cnt <= prime_cnt + 1'b1;
  end
  assign armed = (prime_cnt == PW'(ARM_CNT));

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], pin_in[g]};
    end
    assign in_sync[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= in_sync;
  end

  assign changed = (in_sync ^ prev) & is_input & {NPINS{armed}};

  // A new change wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | changed;
      irq   <= |(flags & en);
    end
  end
endmodule

// File: rtl/uart_iopin_cfg.sv
module uart_iopin_cfg
  import uart_iopin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NPINS-1:0] out_latch,
  input  logic             txc1x,
  input  logic             txc16x,
  input  logic             rxc1x,
  input  logic             rxc16x,
  input  logic             rts_n,
  input  logic             eot_flag,
  input  logic             rts_mode,
  input  logic             eot_mode,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] chg_clr,
  input  logic [NPINS-1:0] chg_en,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] in_sync,
  output logic [NPINS-1:0] chg_flags,
  output logic             irq
);
  logic [CFG_W-1:0] cfg_q;
  src_t             src;

  assign src = '{latch: out_latch, txc1x: txc1x, txc16x: txc16x, rxc1x: rxc1x,
                 rxc16x: rxc16x, rts_n: rts_n, eot: eot_flag,
                 rts_mode: rts_mode, eot_mode: eot_mode};

  iopin_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  iopin_drive_mux u_mux (
    .clk(clk), .rst(rst), .cfg(cfg_q), .src(src), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  iopin_chg_det #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst(rst), .pin_in(pin_in), .is_input(~pin_oe), .clr(chg_clr),
    .en(chg_en), .in_sync(in_sync), .flags(chg_flags), .irq(irq)
  );
endmodule

// File: rtl/uart_iopin_chk.sv
module uart_iopin_chk
  import uart_iopin_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_q,
  input logic [NPINS-1:0] out_latch,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] chg_flags,
  input logic [NPINS-1:0] chg_clr,
  input logic             irq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && chg_flags == '0 && !irq));

  // R3
  pin3_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[7:6] == FLD_SEL_A) |=> (pin_oe[3] && pin_out[3] == $past(out_latch[3])));

  // R2
  pin1_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[3:2] == FLD_SEL_B) |=> !pin_oe[1]);

  // R11
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|chg_flags));

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    // R2
    input_code_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[g*FIELD_W +: FIELD_W] == FLD_INPUT) |=> (!pin_oe[g] && !pin_out[g]));
    // R9
    flag_only_input_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(chg_flags[g]) |-> !$past(pin_oe[g]));
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (chg_flags[g] && !chg_clr[g]) |=> chg_flags[g]);
  end
endmodule

bind uart_iopin_cfg uart_iopin_chk u_chk (
  .clk(clk), .rst(rst), .cfg_q(cfg_q), .out_latch(out_latch), .pin_out(pin_out),
  .pin_oe(pin_oe), .chg_flags(chg_flags), .chg_clr(chg_clr), .irq(irq)
);

// File: tb/sim_uart_iopin_cfg.sv
module sim_uart_iopin_cfg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] out_latch = '0;
  logic       txc1x = 0, txc16x = 0, rxc1x = 0, rxc16x = 0;
  logic       rts_n = 0, eot_flag = 0, rts_mode = 0, eot_mode = 0;
  logic [3:0] pin_in = '0, chg_clr = '0, chg_en = '0;
  logic [3:0] pin_out, pin_oe, in_sync, chg_flags;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_iopin_cfg u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .out_latch(out_latch),
    .txc1x(txc1x), .txc16x(txc16x), .rxc1x(rxc1x), .rxc16x(rxc16x), .rts_n(rts_n),
    .eot_flag(eot_flag), .rts_mode(rts_mode), .eot_mode(eot_mode), .pin_in(pin_in),
    .chg_clr(chg_clr), .chg_en(chg_en), .pin_out(pin_out), .pin_oe(pin_oe),
    .in_sync(in_sync), .chg_flags(chg_flags), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected {oe,val} for one pin, written from the pin maps in R2..R6.
  function automatic logic [1:0] exp_pin(input int idx, input logic [7:0] c);
    logic [1:0] f;
    f = c[idx*2 +: 2];
    if (f == 2'b00) return 2'b00;
    case (idx)
      0: return {1'b1, f == 2'b01 ? out_latch[0] : (f == 2'b10 ? txc1x : txc16x)};
      1: begin
        if (f == 2'b10) return 2'b00;
        if (f == 2'b11) return {1'b1, rxc1x};
        return {1'b1, (c[5:4] != 2'b01 && rts_mode) ? rts_n : out_latch[1]};
      end
      2: begin
        if (f == 2'b10) return {1'b1, rxc1x};
        if (f == 2'b11) return {1'b1, rxc16x};
        return {1'b1, rts_mode ? rts_n : (eot_mode ? eot_flag : out_latch[2])};
      end
      default: return {1'b1, f == 2'b01 ? out_latch[3] : (f == 2'b10 ? txc16x : txc1x)};
    endcase
  endfunction

  function automatic string pin_tag(input int idx, input logic [7:0] c);
    logic [1:0] f;
    f = c[idx*2 +: 2];
    if (f == 2'b00 || (idx == 1 && f == 2'b10)) return "R2";
    case (idx)
      0: return "R4";
      1: return "R6";
      2: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
    tick();
  endtask

  task automatic check_pins(input logic [7:0] c);
    for (int i = 0; i < 4; i++) begin
      logic [1:0] e;
      e = exp_pin(i, c);
      chk(pin_tag(i, c), {6'b0, pin_oe[i], pin_out[i]}, {6'b0, e});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    pin_in = 4'hF;
    @(negedge clk);
    tick(); tick();
    chk("R1 reset", {pin_oe, pin_out}, 8'h00);
    chk("R1 flags", {3'b0, irq, chg_flags}, 8'h00);
    rst = 1'b0;
    tick();
    chk("R1 after release", {pin_oe, pin_out}, 8'h00);
    repeat (6) tick();
    chk("R12 no fill flags", {4'b0, chg_flags}, 8'h00);
    chk("R8 held high", {4'b0, in_sync}, 8'h0F);

    pin_in = 4'h0;
    repeat (5) tick();
    chk("R9 all inputs fall", {4'b0, chg_flags}, 8'h0F);
    chg_clr = 4'h5;
    tick();
    chg_clr = 4'h0;
    chk("R10 clear selected", {4'b0, chg_flags}, 8'h0A);
    chg_clr = 4'hF;
    tick();
    chg_clr = 4'h0;
    chk("R10 clear all", {4'b0, chg_flags}, 8'h00);

    // Single-pin timing: sync delay, flag edge, irq edge.
    chg_en = 4'b0010;
    tick();
    pin_in[1] = 1'b1;
    tick();
    chk("R8 one edge", {7'b0, in_sync[1]}, 8'h00);
    tick();
    chk("R8 two edges", {7'b0, in_sync[1]}, 8'h01);
    chk("R9 not yet", {7'b0, chg_flags[1]}, 8'h00);
    tick();
    chk("R9 flag set", {7'b0, chg_flags[1]}, 8'h01);
    chk("R11 irq not yet", {7'b0, irq}, 8'h00);
    tick();
    chk("R11 irq set", {7'b0, irq}, 8'h01);
    pin_in[1] = 1'b0;
    repeat (4) tick();
    chk("R10 sticky", {7'b0, chg_flags[1]}, 8'h01);
    chg_clr = 4'b0010;
    tick();
    chg_clr = 4'h0;
    chk("R10 cleared", {7'b0, chg_flags[1]}, 8'h00);
    chk("R11 irq lags", {7'b0, irq}, 8'h01);
    tick();
    chk("R11 irq drops", {7'b0, irq}, 8'h00);

    // Masked flag raises no irq.
    pin_in[0] = 1'b1;
    repeat (5) tick();
    chk("R11 masked flag", {3'b0, irq, chg_flags}, 8'h01);
    chg_clr = 4'h1; tick(); chg_clr = 4'h0; tick();

    // Driven pin ignores its pad.
    write_cfg(8'h40);
    pin_in[3] = 1'b1;
    repeat (6) tick();
    chk("R9 driven pin no flag", {7'b0, chg_flags[3]}, 8'h00);
    write_cfg(8'h00);

    // Latency of a configuration write.
    out_latch = 4'h1;
    cfg_we = 1'b1; cfg_wdata = 8'h01;
    tick();
    cfg_we = 1'b0;
    chk("R7 not yet driven", {7'b0, pin_oe[0]}, 8'h00);
    tick();
    chk("R7 driven", {6'b0, pin_oe[0], pin_out[0]}, 8'h03);

    // RTS fallback to pin 1 and back.
    out_latch = 4'hF; rts_mode = 1'b1; rts_n = 1'b0;
    write_cfg(8'h24);
    chk("R6 rts on pin1", {6'b0, pin_oe[1], pin_out[1]}, 8'h02);
    write_cfg(8'h14);
    chk("R6 latch on pin1", {6'b0, pin_oe[1], pin_out[1]}, 8'h03);
    chk("R5 rts on pin2", {6'b0, pin_oe[2], pin_out[2]}, 8'h02);
    rts_mode = 1'b0; eot_mode = 1'b1; eot_flag = 1'b1; out_latch = 4'h0;
    tick(); tick();
    chk("R5 eot on pin2", {6'b0, pin_oe[2], pin_out[2]}, 8'h03);
    write_cfg(8'h08);
    chk("R2 reserved pin1", {6'b0, pin_oe[1], pin_out[1]}, 8'h00);

    // Random configurations and sources.
    pin_in = 4'h0;
    for (int k = 0; k < 60; k++) begin
      logic [7:0] c;
      logic [11:0] r;
      c = 8'($urandom);
      r = 12'($urandom);
      {out_latch, txc1x, txc16x, rxc1x, rxc16x} = r[7:0];
      {rts_n, eot_flag, rts_mode, eot_mode} = r[11:8];
      write_cfg(c);
      check_pins(c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule